// File: doc/BRIEF.md
# Configurable-Frame Serial Transmitter

This block turns bytes written into a small transmit queue into asynchronous serial frames on a single output line. Each frame is a low start bit, five to eight data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. The line control byte selects the frame format and can be changed at run time. A character picks up the format that is in force when its start bit begins.

Bit timing comes from a 16-bit phase accumulator. A 16-bit increment, assembled from two byte-wide divisor inputs, is added to the accumulator on every clock. Each overflow produces one oversample tick, and sixteen ticks make one bit period. The increment is therefore baud × 2^20 / f_clk. Fractional ratios still give the right average rate, with at most one tick of jitter.

The block reports its state through a flag byte: CTS level, busy, queue full and queue empty. It raises a transmit interrupt request when the queue is empty and the interrupt is enabled. A break bit holds the line low. Optional flow control holds back new characters while CTS is low. A global enable stops all serial activity.

Top module: `serial_tx_top`

## Requirements
- R1: After reset the line is high and the flag byte shows busy (bit 3) clear, full (bit 5) clear and empty (bit 7) set.
- R2: A frame starts with one low bit, followed by the data bits LSB first. lineCtl[6:5] selects the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the selected length are not sent.
- R3: When lineCtl[1] is set, a parity bit follows the last data bit. With lineCtl[2] set, parity is even: the data ones plus the parity bit give an even count. With lineCtl[2] clear, parity is odd.
- R4: After the data (and parity) the line is high for one stop bit, or for two stop bits when lineCtl[3] is set. Each character uses the format that lineCtl holds when its start bit begins, so a change made during a frame takes effect from the next character.
- R5: The bit period is 16 overflows of a 16-bit accumulator that adds {baudHi, baudLo} on every clock. This gives a bit period of 16·65536/increment clocks.
- R6: The queue holds 16 characters and sends them in write order. Full (flag bit 5) sets at 16 entries, and a write made while full is discarded.
- R7: With lineCtl[4] clear, the queue acts as a single holding register: full sets after one character, and further writes are discarded.
- R8: Busy (flag bit 3) sets when a start bit begins and clears only after the last stop bit has ended. While busy is clear and break is off, the line is high.
- R9: While lineCtl[0] is set, the line is low, whatever the transmitter is doing.
- R10: Flag bit 0 shows the ctsIn level. With autoFlow set and ctsIn low, no new character is started.
- R11: txIrq is high exactly when txIrqEn is set and the queue is empty.
- R12: With uartEn low, the accumulator is held, no frame is started, and a frame in progress is dropped with the line returned high. The queue keeps its contents and still accepts writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| uartEn | input | 1 | Global enable for the transmitter |
| baudHi | input | 8 | Upper byte of the accumulator increment |
| baudLo | input | 8 | Lower byte of the accumulator increment |
| lineCtl | input | 8 | Frame control: [0] break, [1] parity on, [2] even parity, [3] two stop bits, [4] queue on, [6:5] data length |
| txIrqEn | input | 1 | Transmit interrupt enable |
| autoFlow | input | 1 | Hold new characters while ctsIn is low |
| ctsIn | input | 1 | Clear-to-send level, high means send allowed |
| wrValid | input | 1 | Write strobe for the queue |
| wrData | input | 8 | Character to queue |
| flags | output | 8 | [0] CTS, [3] busy, [5] full, [7] empty, other bits zero |
| txIrq | output | 1 | Transmit interrupt request |
| txOut | output | 1 | Serial line, idles high |

## Verification
Random characters are sent over random frame formats and four increments, one of which (0x6000) gives a non-integer tick interval. These runs separate a wrong length decode, a misplaced parity bit or wrong parity sense, a wrong stop count and accumulator timing errors. Directed runs fill the queue past its depth in both queue modes, to separate the 16-entry queue from the one-character holding register. A format change during a frame shows that the format is sampled per character. The remaining directed runs cover CTS gating, the enable, break and the interrupt request, each against a line that would otherwise carry a frame.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  localparam int LC_BREAK   = 0;
  localparam int LC_PAR_EN  = 1;
  localparam int LC_PAR_EVN = 2;
  localparam int LC_STOP2   = 3;
  localparam int LC_FIFO_EN = 4;
  localparam int LC_LEN_LO  = 5;
  localparam int LC_LEN_HI  = 6;

  localparam int FL_CTS   = 0;
  localparam int FL_BUSY  = 3;
  localparam int FL_FULL  = 5;
  localparam int FL_EMPTY = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_t;

  typedef struct packed {
    logic load;
    logic nextData;
    logic sendParity;
    logic sendStop;
    logic goIdle;
  } txStrobe_t;

endpackage

// File: rtl/serial_tx_baud.sv
module serial_tx_baud #(
  parameter int INC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [INC_W-1:0] incr,
  output logic             tick
);
  logic [INC_W-1:0] acc;
  logic [INC_W:0]   sum;

  assign sum = {1'b0, acc} + {1'b0, incr};

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      acc  <= '0;
      tick <= 1'b0;
    end else begin
      acc  <= sum[INC_W-1:0];
      tick <= sum[INC_W];
    end
  end
endmodule

// File: rtl/serial_tx_fifo.sv
module serial_tx_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  input  logic              single,
  output logic [DATA_W-1:0] popData,
  output logic              full,
  output logic              empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [CW-1:0]     count;
  logic              accept, take;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = single ? (count != '0) : (count == CW'(DEPTH));
  assign accept  = push && !full;
  assign take    = pop && !empty;
  assign popData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (accept) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (accept) wrPtr <= bump(wrPtr);
      if (take)   rdPtr <= bump(rdPtr);
      case ({accept, take})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/serial_tx_ctrl.sv
module serial_tx_ctrl
  import serial_tx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       uartEn,
  input  logic       tick,
  input  logic       fifoEmpty,
  input  logic [7:0] lineCtl,
  input  logic       autoFlow,
  input  logic       ctsIn,
  output txStrobe_t  strobe,
  output logic       busy
);
  localparam int TW = (OVS > 1) ? $clog2(OVS) : 1;

  txState_t      state, stateN;
  logic [TW-1:0] tickCnt;
  logic [2:0]    bitIdx;
  logic          stopIdx;
  logic [1:0]    lenQ;
  logic          parEnQ, twoStopQ;
  logic          bitEnd, lastData;

  assign bitEnd   = tick && (tickCnt == TW'(OVS - 1));
  assign lastData = (bitIdx == (3'(lenQ) + 3'd4));
  assign busy     = (state != ST_IDLE);

  always_comb begin
    stateN = state;
    strobe = '0;
    if (!uartEn) begin
      stateN        = ST_IDLE;
      strobe.goIdle = 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!fifoEmpty && (!autoFlow || ctsIn)) begin
            strobe.load = 1'b1;
            stateN      = ST_START;
          end
        end
        ST_START: begin
          if (bitEnd) begin
            strobe.nextData = 1'b1;
            stateN          = ST_DATA;
          end
        end
        ST_DATA: begin
          if (bitEnd) begin
            if (!lastData) begin
              strobe.nextData = 1'b1;
            end else if (parEnQ) begin
              strobe.sendParity = 1'b1;
              stateN            = ST_PARITY;
            end else begin
              strobe.sendStop = 1'b1;
              stateN          = ST_STOP;
            end
          end
        end
        ST_PARITY: begin
          if (bitEnd) begin
            strobe.sendStop = 1'b1;
            stateN          = ST_STOP;
          end
        end
        ST_STOP: begin
          if (bitEnd && (!twoStopQ || stopIdx)) stateN = ST_IDLE;
        end
        default: stateN = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tickCnt  <= '0;
      bitIdx   <= '0;
      stopIdx  <= 1'b0;
      lenQ     <= 2'b11;
      parEnQ   <= 1'b0;
      twoStopQ <= 1'b0;
    end else begin
      state <= stateN;
      if (strobe.load || !uartEn) tickCnt <= '0;
      else if (tick) tickCnt <= (tickCnt == TW'(OVS - 1)) ? '0 : tickCnt + 1'b1;
      if (strobe.load) begin
        bitIdx   <= '0;
        lenQ     <= lineCtl[LC_LEN_HI:LC_LEN_LO];
        parEnQ   <= lineCtl[LC_PAR_EN];
        twoStopQ <= lineCtl[LC_STOP2];
      end else if (strobe.nextData && state == ST_DATA) begin
        bitIdx <= bitIdx + 1'b1;
      end
      if (strobe.sendStop) stopIdx <= 1'b0;
      else if (state == ST_STOP && bitEnd) stopIdx <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_tx_dp.sv
module serial_tx_dp
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        lenCode,
  input  logic              evenPar,
  output logic              txLine
);
  localparam int MIN_BITS = DATA_W - 3;

  logic [DATA_W-1:0] shreg, masked;
  logic              parity, parQ, lineQ;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      masked[i] = data[i] && (i < (MIN_BITS + int'(lenCode)));
    end
    parity = evenPar ? (^masked) : ~(^masked);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shreg <= '0;
      parQ  <= 1'b0;
      lineQ <= 1'b1;
    end else if (strobe.goIdle || strobe.sendStop) begin
      lineQ <= 1'b1;
    end else if (strobe.load) begin
      shreg <= masked;
      parQ  <= parity;
      lineQ <= 1'b0;
    end else if (strobe.nextData) begin
      lineQ <= shreg[0];
      shreg <= shreg >> 1;
    end else if (strobe.sendParity) begin
      lineQ <= parQ;
    end
  end

  assign txLine = lineQ;
endmodule

// File: rtl/serial_tx_top.sv
module serial_tx_top
  import serial_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DATA_W     = 8,
  parameter int INC_W      = 16,
  parameter int OVS        = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              uartEn,
  input  logic [7:0]        baudHi,
  input  logic [7:0]        baudLo,
  input  logic [7:0]        lineCtl,
  input  logic              txIrqEn,
  input  logic              autoFlow,
  input  logic              ctsIn,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  output logic [7:0]        flags,
  output logic              txIrq,
  output logic              txOut
);
  txStrobe_t         strobe;
  logic              tick, busy, fifoFull, fifoEmpty, lineQ;
  logic [DATA_W-1:0] popData;

  serial_tx_baud #(.INC_W(INC_W)) baud_i (
    .clk(clk), .rstN(rstN), .enable(uartEn),
    .incr(INC_W'({baudHi, baudLo})), .tick(tick)
  );

  serial_tx_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) fifo_i (
    .clk(clk), .rstN(rstN), .push(wrValid), .pushData(wrData),
    .pop(strobe.load), .single(!lineCtl[LC_FIFO_EN]),
    .popData(popData), .full(fifoFull), .empty(fifoEmpty)
  );

  serial_tx_ctrl #(.OVS(OVS)) ctrl_i (
    .clk(clk), .rstN(rstN), .uartEn(uartEn), .tick(tick),
    .fifoEmpty(fifoEmpty), .lineCtl(lineCtl), .autoFlow(autoFlow),
    .ctsIn(ctsIn), .strobe(strobe), .busy(busy)
  );

  serial_tx_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .data(popData),
    .lenCode(lineCtl[LC_LEN_HI:LC_LEN_LO]), .evenPar(lineCtl[LC_PAR_EVN]),
    .txLine(lineQ)
  );

  always_comb begin
    flags           = '0;
    flags[FL_CTS]   = ctsIn;
    flags[FL_BUSY]  = busy;
    flags[FL_FULL]  = fifoFull;
    flags[FL_EMPTY] = fifoEmpty;
  end

  assign txIrq = txIrqEn && fifoEmpty;
  assign txOut = lineQ && !lineCtl[LC_BREAK];
endmodule

// File: rtl/serial_tx_chk.sv
module serial_tx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       uartEn,
  input logic [7:0] lineCtl,
  input logic       autoFlow,
  input logic       ctsIn,
  input logic       wrValid,
  input logic [7:0] flags,
  input logic       txOut
);
  p_break_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    lineCtl[0] |-> !txOut);

  p_idle_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!flags[3] && !lineCtl[0]) |-> txOut);

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(flags[3]) && !lineCtl[0]) |-> !txOut);

  p_full_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(flags[5] && flags[7]));

  p_cts_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (autoFlow && !ctsIn && !flags[3] && uartEn) |=> !flags[3]);

  p_disable_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    !uartEn |=> !flags[3]);

  p_disable_keep_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!uartEn && !wrValid) |=> $stable(flags[7]));
endmodule

bind serial_tx_top serial_tx_chk chk_i (
  .clk(clk), .rstN(rstN), .uartEn(uartEn), .lineCtl(lineCtl),
  .autoFlow(autoFlow), .ctsIn(ctsIn), .wrValid(wrValid),
  .flags(flags), .txOut(txOut)
);

// File: tb/serial_tx_top_tb_top.sv
module serial_tx_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       uartEn = 1'b0;
  logic [7:0] baudHi = 8'h80, baudLo = 8'h00;
  logic [7:0] lineCtl = 8'h70;
  logic       txIrqEn = 1'b0, autoFlow = 1'b0, ctsIn = 1'b1;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] flags;
  logic       txIrq, txOut;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  serial_tx_top dut_i (
    .clk(clk), .rstN(rstN), .uartEn(uartEn), .baudHi(baudHi), .baudLo(baudLo),
    .lineCtl(lineCtl), .txIrqEn(txIrqEn), .autoFlow(autoFlow), .ctsIn(ctsIn),
    .wrValid(wrValid), .wrData(wrData), .flags(flags), .txIrq(txIrq), .txOut(txOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mkLc(input bit brk, input bit pe, input bit ev,
                                      input bit two, input bit fe, input logic [1:0] len);
    return {1'b0, len, fe, two, ev, pe, brk};
  endfunction

  function automatic int maskData(input int d, input int nBits);
    return d & ((1 << nBits) - 1);
  endfunction

  function automatic bit expPar(input int d, input int nBits, input bit even);
    bit odd = ^(maskData(d, nBits));
    return even ? odd : !odd;
  endfunction

  function automatic real bitPeriod(input int inc);
    return 16.0 * 65536.0 / real'(inc);
  endfunction

  task automatic setInc(input int inc);
    @(negedge clk);
    baudHi = 8'(inc >> 8);
    baudLo = 8'(inc);
  endtask

  task automatic pushChar(input logic [7:0] d);
    @(negedge clk);
    wrValid = 1'b1;
    wrData  = d;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic recvFrame(input int nBits, input bit pe, input bit ev, input bit two,
                           input real per, input bit checkIdle, output int got);
    int  waitCnt = 0;
    int  cyc = 0;
    int  total;
    bit  b;
    bit  par = 1'b0;
    got = 0;
    while (txOut !== 1'b0 && waitCnt < 4000) begin
      @(negedge clk);
      waitCnt++;
    end
    if (waitCnt >= 4000) begin
      chk(1'b0, "R2 start bit never seen", int'(txOut), 0);
      return;
    end
    total = 1 + nBits + int'(pe) + 1 + int'(two);
    for (int k = 0; k < total; k++) begin
      while (real'(cyc) < (real'(k) + 0.5) * per) begin
        @(negedge clk);
        cyc++;
      end
      b = txOut;
      if (k == 0) chk(b == 1'b0, "R2 start bit low", int'(b), 0);
      else if (k <= nBits) got |= int'(b) << (k - 1);
      else if (pe && k == nBits + 1) par = b;
      else begin
        chk(b == 1'b1, "R4 stop bit high", int'(b), 1);
        if (k == total - 1) chk(flags[3] == 1'b1, "R8 busy during last stop", int'(flags[3]), 1);
      end
    end
    if (pe) chk(par == expPar(got, nBits, ev), "R3 parity bit", int'(par), int'(expPar(got, nBits, ev)));
    if (checkIdle) begin
      repeat (int'(per / 2.0) + 6) @(negedge clk);
      chk(flags[3] == 1'b0, "R8 busy clears after stop", int'(flags[3]), 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    int got, lows;
    int incs[4] = '{32'h8000, 32'h4000, 32'h5555, 32'h6000};
    logic [7:0] sent[17];
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txOut == 1'b1, "R1 line high after reset", int'(txOut), 1);
    chk(flags == 8'h81, "R1 flags after reset", int'(flags), 8'h81);
    uartEn = 1'b1;

    // R2 directed 8N1
    pushChar(8'hA5);
    recvFrame(8, 0, 0, 0, bitPeriod(32'h8000), 1, got);
    chk(got == 32'hA5, "R2 data 8N1", got, 32'hA5);

    // R5 start bit plus a zero data bit form a low run of two bit periods
    setInc(32'h4000);
    pushChar(8'hFE);
    while (txOut !== 1'b0) @(negedge clk);
    lows = 0;
    while (txOut === 1'b0 && lows < 1000) begin @(negedge clk); lows++; end
    chk(lows >= 124 && lows <= 132, "R5 two-bit low run length", lows, 128);
    repeat (1200) @(negedge clk);

    // R2 R3 R4 R5 random formats
    for (int it = 0; it < 30; it++) begin
      int inc = incs[$urandom_range(0, 3)];
      logic [1:0] len = 2'($urandom_range(0, 3));
      bit pe = 1'($urandom_range(0, 1));
      bit ev = 1'($urandom_range(0, 1));
      bit two = 1'($urandom_range(0, 1));
      logic [7:0] d = 8'($urandom_range(0, 255));
      setInc(inc);
      lineCtl = mkLc(0, pe, ev, two, 1, len);
      pushChar(d);
      recvFrame(5 + int'(len), pe, ev, two, bitPeriod(inc), 1, got);
      chk(got == maskData(int'(d), 5 + int'(len)), "R2 random data", got, maskData(int'(d), 5 + int'(len)));
    end

    // R4 format change mid-frame applies to next character
    setInc(32'h4000);
    lineCtl = mkLc(0, 1, 1, 1, 1, 2'b11);
    pushChar(8'h3C);
    repeat (3) @(negedge clk);
    lineCtl = mkLc(0, 1, 0, 0, 1, 2'b00);
    pushChar(8'h1F);
    recvFrame(8, 1, 1, 1, bitPeriod(32'h4000), 0, got);
    chk(got == 32'h3C, "R4 first char keeps old format", got, 32'h3C);
    recvFrame(5, 1, 0, 0, bitPeriod(32'h4000), 1, got);
    chk(got == 32'h1F, "R4 second char uses new format", got, 32'h1F);

    // R6 R12 queue depth with transmitter disabled
    setInc(32'h8000);
    lineCtl = mkLc(0, 0, 0, 0, 1, 2'b11);
    uartEn = 1'b0;
    for (int i = 0; i < 17; i++) begin
      sent[i] = 8'($urandom_range(0, 255));
      pushChar(sent[i]);
      if (i == 14) chk(flags[5] == 1'b0, "R6 not full at 15", int'(flags[5]), 0);
      if (i == 15) chk(flags[5] == 1'b1, "R6 full at 16", int'(flags[5]), 1);
    end
    repeat (200) @(negedge clk);
    chk(txOut == 1'b1 && flags[3] == 1'b0, "R12 no frame while disabled", int'(flags[3]), 0);
    chk(flags[7] == 1'b0, "R12 queue kept while disabled", int'(flags[7]), 0);
    uartEn = 1'b1;
    for (int i = 0; i < 16; i++) begin
      recvFrame(8, 0, 0, 0, bitPeriod(32'h8000), i == 15, got);
      chk(got == int'(sent[i]), "R6 queue order", got, int'(sent[i]));
    end
    chk(flags[7] == 1'b1, "R6 empty after drain, 17th discarded", int'(flags[7]), 1);
    lows = 0;
    repeat (400) begin @(negedge clk); if (!txOut) lows++; end
    chk(lows == 0, "R6 no extra frame", lows, 0);

    // R7 holding register mode
    uartEn = 1'b0;
    lineCtl = mkLc(0, 0, 0, 0, 0, 2'b11);
    pushChar(8'h5A);
    chk(flags[5] == 1'b1, "R7 full after one", int'(flags[5]), 1);
    pushChar(8'hC3);
    uartEn = 1'b1;
    recvFrame(8, 0, 0, 0, bitPeriod(32'h8000), 1, got);
    chk(got == 32'h5A, "R7 held char sent", got, 32'h5A);
    lows = 0;
    repeat (400) begin @(negedge clk); if (!txOut) lows++; end
    chk(lows == 0, "R7 second write discarded", lows, 0);
    lineCtl = mkLc(0, 0, 0, 0, 1, 2'b11);

    // R9 break
    @(negedge clk);
    lineCtl = mkLc(1, 0, 0, 0, 1, 2'b11);
    repeat (5) @(negedge clk);
    chk(txOut == 1'b0, "R9 break forces low", int'(txOut), 0);
    lineCtl = mkLc(0, 0, 0, 0, 1, 2'b11);
    @(negedge clk);
    chk(txOut == 1'b1, "R9 line high after break", int'(txOut), 1);

    // R10 CTS gating
    autoFlow = 1'b1;
    ctsIn = 1'b0;
    @(negedge clk);
    chk(flags[0] == 1'b0, "R10 CTS flag low", int'(flags[0]), 0);
    pushChar(8'h96);
    repeat (300) @(negedge clk);
    chk(txOut == 1'b1 && flags[3] == 1'b0, "R10 held while CTS low", int'(flags[3]), 0);
    ctsIn = 1'b1;
    @(negedge clk);
    chk(flags[0] == 1'b1, "R10 CTS flag high", int'(flags[0]), 1);
    recvFrame(8, 0, 0, 0, bitPeriod(32'h8000), 1, got);
    chk(got == 32'h96, "R10 sent after CTS", got, 32'h96);
    autoFlow = 1'b0;

    // R11 interrupt request
    txIrqEn = 1'b1;
    @(negedge clk);
    chk(txIrq == 1'b1, "R11 irq when empty", int'(txIrq), 1);
    uartEn = 1'b0;
    pushChar(8'h11);
    chk(txIrq == 1'b0, "R11 no irq with pending char", int'(txIrq), 0);
    uartEn = 1'b1;
    recvFrame(8, 0, 0, 0, bitPeriod(32'h8000), 1, got);
    chk(txIrq == 1'b1, "R11 irq after drain", int'(txIrq), 1);
    txIrqEn = 1'b0;
    @(negedge clk);
    chk(txIrq == 1'b0, "R11 irq masked", int'(txIrq), 0);

    // R12 abort mid-frame
    pushChar(8'h00);
    repeat (40) @(negedge clk);
    uartEn = 1'b0;
    @(negedge clk);
    chk(txOut == 1'b1 && flags[3] == 1'b0, "R12 abort returns line high", int'(txOut), 1);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule